// File: doc/BRIEF.md
# Aliased Miscellaneous Status Register with Level Interrupt

This block holds one 64-bit control and status word on a register bus that only takes 8-byte accesses. Bits are numbered big-endian: bit 0 is the most significant bit of the bus word, which is vector index 63. Bits 0 to 18 are implemented. Every other bit always reads back as zero.

Software reaches the word through a small group of consecutive word addresses above a base set by a parameter. The word at the base is read with a plain load and written with a plain store. The word at base+1 merges the written data into the register with a bitwise AND. The word at base+2 merges it with a bitwise OR. A parameter turns the base+1 alias into a clear-all instead: any store there zeroes the whole register, whatever the data. The word offset is the byte address shifted right by three.

Bit 0 drives the interrupt output as a level. A side input lets a message engine post a shared-memory message in one step: it sets bit 0 (the interrupt) and bit 3 (the message flag) together. If that input and a bus store arrive in the same cycle, the store is applied first and the two bits are ORed in afterwards.

Top module: `misc_alias_reg`

## Requirements
- R1: While reset is held, and in the first cycle after it, the register reads as zero and `irq_o` is low.
- R2: A valid store to word offset base+0 replaces the register with the store data ANDed with the implemented-bit mask: vector bits [63:45] are kept and bits [44:0] are forced to zero.
- R3: A valid load at word offset base+0 returns the register value in the same cycle. A load at any other offset, or one that is not 8 bytes wide, returns zero.
- R4: With `CLEAR_ON_AND` = 0, a valid store to base+1 sets the register to its current value ANDed with the store data.
- R5: With `CLEAR_ON_AND` = 1, a valid store to base+1 sets the register to zero, whatever the store data.
- R6: A valid store to base+2 sets the register to its current value ORed with the masked store data.
- R7: `irq_o` equals big-endian bit 0 (vector bit 63) of the register, as a level that changes in the same cycle as the register.
- R8: A pulse on `msg_raise_i` ORs big-endian bits 0 and 3 (vector bits 63 and 60) into the register one clock later and leaves every other bit unchanged.
- R9: When `msg_raise_i` and a valid store arrive in the same cycle, the store result is formed first and bits 0 and 3 are ORed into it.
- R10: A store whose size is not 8 bytes, or that targets an offset outside base+0..base+2, leaves the register unchanged.
- R11: The low three bits of the byte address do not affect decoding; only the word offset (address shifted right by 3) selects the alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Store strobe |
| bus_rd_i | input | 1 | Load strobe |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_size_i | input | SIZE_W | Access size in bytes; only 8 is valid |
| bus_wdata_i | input | DATA_W | Store data, big-endian bit numbering |
| bus_rdata_o | output | DATA_W | Load data, combinational |
| msg_raise_i | input | 1 | Message-engine pulse that sets the interrupt and message bits |
| irq_o | output | 1 | Level interrupt taken from register bit 0 |

## Verification
The assertions assume that `bus_wr_i`, `bus_addr_i`, `bus_size_i`, `bus_wdata_i` and `msg_raise_i` are stable and free of X at every active clock edge once reset is released. They make no assumption about how strobes are spaced, so back-to-back stores and a store landing together with a raise are both legal. The bench changes inputs only on the falling edge, drives every input to a known value from time zero, and includes same-cycle store-plus-raise cycles, odd sizes, stray offsets and non-zero low address bits, so every assumption is honoured while the corner cases are still reached.

// File: rtl/misc_alias_pkg.sv
package misc_alias_pkg;

    // Operation selected by the address decoder for one bus cycle.
    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_DIRECT = 3'd1,
        OP_AND    = 3'd2,
        OP_OR     = 3'd3,
        OP_CLEAR  = 3'd4
    } op_e;

    // Word offsets of the aliases relative to the base word.
    localparam int OFS_DIRECT = 0;
    localparam int OFS_MERGE  = 1;
    localparam int OFS_SET    = 2;

endpackage

// File: rtl/misc_alias_decode.sv
module misc_alias_decode
    import misc_alias_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int SIZE_W       = 4,
    parameter int DATA_W       = 64,
    parameter int BASE_WORD    = 'h4020,
    parameter bit CLEAR_ON_AND = 1'b0
) (
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SIZE_W-1:0] size_i,
    output op_e               op_o,
    output logic              rd_hit_o
);

    localparam int WORD_BYTES = DATA_W / 8;
    localparam int WORD_SHIFT = $clog2(WORD_BYTES);
    localparam logic [ADDR_W-1:0] W_DIRECT = ADDR_W'(BASE_WORD + OFS_DIRECT);
    localparam logic [ADDR_W-1:0] W_MERGE  = ADDR_W'(BASE_WORD + OFS_MERGE);
    localparam logic [ADDR_W-1:0] W_SET    = ADDR_W'(BASE_WORD + OFS_SET);
    localparam logic [SIZE_W-1:0] SIZE_OK  = SIZE_W'(WORD_BYTES);

    logic [ADDR_W-1:0] word_ofs;
    logic              size_good;
    logic              hit_direct;
    logic              hit_merge;
    logic              hit_set;
    op_e               merge_op;

    assign word_ofs   = addr_i >> WORD_SHIFT;
    assign size_good  = (size_i == SIZE_OK);
    assign hit_direct = (word_ofs == W_DIRECT);
    assign hit_merge  = (word_ofs == W_MERGE);
    assign hit_set    = (word_ofs == W_SET);

    // The variant parameter picks what the base+1 alias does.
    generate
        if (CLEAR_ON_AND) begin : g_clear_alias
            assign merge_op = OP_CLEAR;
        end else begin : g_and_alias
            assign merge_op = OP_AND;
        end
    endgenerate

    always_comb begin
        op_o = OP_NONE;
        if (wr_i && size_good) begin
            if (hit_direct) begin
                op_o = OP_DIRECT;
            end else if (hit_merge) begin
                op_o = merge_op;
            end else if (hit_set) begin
                op_o = OP_OR;
            end
        end
    end

    assign rd_hit_o = rd_i && size_good && hit_direct;

endmodule

// File: rtl/misc_alias_update.sv
module misc_alias_update
    import misc_alias_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int IMPL_BITS = 19,
    parameter int IRQ_BIT   = 0,
    parameter int MSG_BIT   = 3
) (
    input  logic [DATA_W-1:0] cur_i,
    input  op_e               op_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              raise_i,
    output logic [DATA_W-1:0] next_o
);

    localparam int IRQ_IDX = DATA_W - 1 - IRQ_BIT;
    localparam int MSG_IDX = DATA_W - 1 - MSG_BIT;

    logic [DATA_W-1:0] impl_mask;
    logic [DATA_W-1:0] raise_bits;
    logic [DATA_W-1:0] bus_result;

    // Big-endian numbering: bit n of the register is vector index DATA_W-1-n.
    generate
        for (genvar n = 0; n < DATA_W; n++) begin : g_mask
            assign impl_mask[DATA_W-1-n] = (n < IMPL_BITS);
        end
    endgenerate

    always_comb begin
        raise_bits          = '0;
        raise_bits[IRQ_IDX] = 1'b1;
        raise_bits[MSG_IDX] = 1'b1;
    end

    always_comb begin
        unique case (op_i)
            OP_DIRECT: bus_result = wdata_i;
            OP_AND:    bus_result = cur_i & wdata_i;
            OP_OR:     bus_result = cur_i | wdata_i;
            OP_CLEAR:  bus_result = '0;
            default:   bus_result = cur_i;
        endcase
    end

    // The bus result is formed first, the message raise is merged after it.
    assign next_o = (bus_result & impl_mask) | (raise_i ? (raise_bits & impl_mask) : '0);

endmodule

// File: rtl/misc_alias_reg.sv
module misc_alias_reg
    import misc_alias_pkg::*;
#(
    parameter int DATA_W       = 64,
    parameter int ADDR_W       = 20,
    parameter int SIZE_W       = 4,
    parameter int IMPL_BITS    = 19,
    parameter int IRQ_BIT      = 0,
    parameter int MSG_BIT      = 3,
    parameter int BASE_WORD    = 'h4020,
    parameter bit CLEAR_ON_AND = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [SIZE_W-1:0] bus_size_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              msg_raise_i,
    output logic              irq_o
);

    localparam int IRQ_IDX    = DATA_W - 1 - IRQ_BIT;
    localparam int MSG_IDX    = DATA_W - 1 - MSG_BIT;
    localparam int WORD_SHIFT = $clog2(DATA_W / 8);

    function automatic logic [DATA_W-1:0] build_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int n = 0; n < IMPL_BITS; n++) begin
            m[DATA_W-1-n] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [DATA_W-1:0] IMPL_MASK = build_mask();

    typedef struct packed {
        logic [DATA_W-1:0] misc;
        logic              irq;
    } state_t;

    state_t            state_d;
    state_t            state_q;
    op_e               op;
    logic              rd_hit;
    logic [DATA_W-1:0] misc_next;

    misc_alias_decode #(
        .ADDR_W       (ADDR_W),
        .SIZE_W       (SIZE_W),
        .DATA_W       (DATA_W),
        .BASE_WORD    (BASE_WORD),
        .CLEAR_ON_AND (CLEAR_ON_AND)
    ) u_decode (
        .wr_i     (bus_wr_i),
        .rd_i     (bus_rd_i),
        .addr_i   (bus_addr_i),
        .size_i   (bus_size_i),
        .op_o     (op),
        .rd_hit_o (rd_hit)
    );

    misc_alias_update #(
        .DATA_W    (DATA_W),
        .IMPL_BITS (IMPL_BITS),
        .IRQ_BIT   (IRQ_BIT),
        .MSG_BIT   (MSG_BIT)
    ) u_update (
        .cur_i   (state_q.misc),
        .op_i    (op),
        .wdata_i (bus_wdata_i),
        .raise_i (msg_raise_i),
        .next_o  (misc_next)
    );

    always_comb begin
        state_d      = state_q;
        state_d.misc = misc_next;
        state_d.irq  = misc_next[IRQ_IDX];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bus_rdata_o = rd_hit ? state_q.misc : '0;
    assign irq_o       = state_q.irq;

    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.misc & ~IMPL_MASK) == '0);  // R2

    AST_IRQ_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == state_q.misc[IRQ_IDX]);  // R7

    AST_RAISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        msg_raise_i |=> (irq_o && state_q.misc[MSG_IDX]));  // R8

    AST_OR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_OR) |=> ((state_q.misc & $past(bus_wdata_i & IMPL_MASK))
                           == $past(bus_wdata_i & IMPL_MASK)));  // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NONE && !msg_raise_i) |=> $stable(state_q.misc));  // R10

    AST_STRAY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr_i >> WORD_SHIFT) != ADDR_W'(BASE_WORD)) |-> (bus_rdata_o == '0));  // R3

    generate
        if (CLEAR_ON_AND) begin : g_chk_clear
            AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
                (op == OP_CLEAR && !msg_raise_i) |=> (state_q.misc == '0));  // R5
        end
    endgenerate

endmodule

// File: tb/tb_misc_alias_reg.sv
module tb_misc_alias_reg;

    localparam int DW     = 64;
    localparam int AW     = 20;
    localparam int BASE_A = 'h4020;
    localparam int BASE_B = 'h6080;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr = 1'b0;
    logic          rd = 1'b0;
    logic [AW-1:0] addr_a = '0;
    logic [AW-1:0] addr_b = '0;
    logic [3:0]    size = 4'd8;
    logic [DW-1:0] wdata = '0;
    logic          raise = 1'b0;
    logic [DW-1:0] rdata_a;
    logic [DW-1:0] rdata_b;
    logic          irq_a;
    logic          irq_b;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [DW-1:0] ma = '0;
    logic [DW-1:0] mb = '0;

    always #4 clk = ~clk;

    misc_alias_reg #(.BASE_WORD(BASE_A), .CLEAR_ON_AND(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_addr_i(addr_a), .bus_size_i(size), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata_a), .msg_raise_i(raise), .irq_o(irq_a));

    misc_alias_reg #(.BASE_WORD(BASE_B), .CLEAR_ON_AND(1'b1)) dut_b (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_addr_i(addr_b), .bus_size_i(size), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata_b), .msg_raise_i(raise), .irq_o(irq_b));

    function automatic logic [DW-1:0] impl_mask();
        logic [DW-1:0] m = '0;
        for (int n = 0; n <= 18; n++) m[63-n] = 1'b1;
        return m;
    endfunction

    function automatic logic [DW-1:0] model_next(logic [DW-1:0] cur, bit variant_b,
        int ofs, bit w, int sz, logic [DW-1:0] d, bit r);
        logic [DW-1:0] v = cur;
        if (w && sz == 8) begin
            if (ofs == 0) v = d;
            else if (ofs == 1) v = variant_b ? '0 : (cur & d);
            else if (ofs == 2) v = cur | d;
        end
        v = v & impl_mask();
        if (r) begin
            v[63] = 1'b1;
            v[60] = 1'b1;
        end
        return v;
    endfunction

    task automatic check64(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive on the falling edge, check, then advance the model.
    task automatic step(string tag, int ofs, int lo, bit w, bit r, int sz,
                        logic [DW-1:0] d, bit rs);
        logic [DW-1:0] exp_a;
        logic [DW-1:0] exp_b;
        @(negedge clk);
        wr     = w;
        rd     = r;
        size   = sz[3:0];
        wdata  = d;
        raise  = rs;
        addr_a = AW'(((BASE_A + ofs) << 3) + lo);
        addr_b = AW'(((BASE_B + ofs) << 3) + lo);
        #2;
        exp_a = (r && sz == 8 && ofs == 0) ? ma : '0;
        exp_b = (r && sz == 8 && ofs == 0) ? mb : '0;
        check64({tag, " rdata A"}, rdata_a, exp_a);
        check64({tag, " rdata B"}, rdata_b, exp_b);
        check64({tag, " R7 irq A"}, {63'd0, irq_a}, {63'd0, ma[63]});
        check64({tag, " R7 irq B"}, {63'd0, irq_b}, {63'd0, mb[63]});
        @(posedge clk);
        ma = model_next(ma, 1'b0, ofs, w, sz, d, rs);
        mb = model_next(mb, 1'b1, ofs, w, sz, d, rs);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: state under reset
        repeat (3) @(negedge clk);
        rd = 1'b1;
        addr_a = AW'(BASE_A << 3);
        addr_b = AW'(BASE_B << 3);
        #2;
        check64("R1 reset rdata A", rdata_a, '0);
        check64("R1 reset rdata B", rdata_b, '0);
        check64("R1 reset irq", {62'd0, irq_a, irq_b}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        step("R1 after reset", 0, 0, 0, 1, 8, '0, 0);

        // R2: direct store, masked to implemented bits
        step("R2 store ones", 0, 0, 1, 0, 8, '1, 0);
        step("R3 read back", 0, 0, 0, 1, 8, '0, 0);
        step("R2 store pattern", 0, 0, 1, 1, 8, 64'h7A5C_3F00_FFFF_1234, 0);
        step("R3 read direct", 0, 0, 0, 1, 8, '0, 0);
        // R3: other offsets and bad size read zero
        step("R3 read ofs1", 1, 0, 0, 1, 8, '0, 0);
        step("R3 read ofs2", 2, 0, 0, 1, 8, '0, 0);
        step("R3 read size4", 0, 0, 0, 1, 4, '0, 0);

        // R4 / R5: base+1 alias
        step("R4 R5 merge store", 1, 0, 1, 0, 8, 64'h3FFF_0000_0000_0000, 0);
        step("R4 R5 read", 0, 0, 0, 1, 8, '0, 0);

        // R6: OR alias, raising bit 0 and so the interrupt (R7)
        step("R6 or store", 2, 0, 1, 0, 8, 64'h8400_2000_0000_00FF, 0);
        step("R6 R7 read", 0, 0, 0, 1, 8, '0, 0);
        step("R4 and drops irq", 1, 0, 1, 0, 8, 64'h7FFF_FFFF_FFFF_FFFF, 0);
        step("R7 read", 0, 0, 0, 1, 8, '0, 0);

        // R8: message raise alone
        step("R8 raise", 5, 0, 0, 0, 8, '0, 1);
        step("R8 read", 0, 0, 0, 1, 8, '0, 0);

        // R9: store and raise together
        step("R9 store zero plus raise", 0, 0, 1, 0, 8, '0, 1);
        step("R9 read", 0, 0, 0, 1, 8, '0, 0);
        step("R9 merge plus raise", 1, 0, 1, 0, 8, 64'h0000_4000_0000_0000, 1);
        step("R9 read 2", 0, 0, 0, 1, 8, '0, 0);

        // R10: ignored stores
        step("R10 size4 store", 0, 0, 1, 0, 4, 64'h1234_5000_0000_0000, 0);
        step("R10 read", 0, 0, 0, 1, 8, '0, 0);
        step("R10 ofs3 store", 3, 0, 1, 0, 8, '0, 0);
        step("R10 low ofs store", -32, 0, 1, 0, 8, '0, 0);
        step("R10 read 2", 0, 0, 0, 1, 8, '0, 0);

        // R11: low address bits are ignored
        step("R11 store lo5", 0, 5, 1, 0, 8, 64'h1111_2000_0000_0000, 0);
        step("R11 read lo7", 0, 7, 0, 1, 8, '0, 0);
        step("R11 or lo3", 2, 3, 1, 0, 8, 64'h8000_0000_0000_0000, 0);
        step("R11 read", 0, 0, 0, 1, 8, '0, 0);

        // R7: direct store with bit 0 clear drops the interrupt
        step("R7 clear irq", 0, 0, 1, 0, 8, 64'h0F00_0000_0000_0000, 0);
        step("R7 final read", 0, 0, 0, 1, 8, '0, 0);
        step("final idle", 0, 0, 0, 1, 8, '0, 0);

        finish_run();
    end

endmodule